// File: doc/BRIEF.md
# Overlay Host Register and Content FIFO Interface

This block is a slave on a 32-bit host bus. Each host write is routed by its address. It goes either into a content FIFO that feeds the overlay pixel path, or into the control registers. Content words are stored exactly as written. The pixel path pops them later through a simple strobe port in the host clock domain. That consumer, the unpacking and the colour lookup are outside this block.

The control registers form two groups.

- **Static group.** Enable, pixel width and a self-clearing soft reset. These settings take effect on the next clock.
- **Window group.** The overlay position and size. The host writes a shadow copy. The video clock domain copies it into the active window outputs on the rising edge of vertical sync, so the window never moves partway through a frame.

The FIFO level drives a DMA request with hysteresis, and one-cycle interrupt pulses on entry into the full and empty states. With these the host can pace its writes.

Top module: `osd_hif_top`

## Requirements
- R1: A write to offset 0x00 stores the 32-bit word unchanged in the FIFO. Words leave in write order. `pop_data` holds a popped word from the clock edge after the pop strobe.
- R2: A write to offset 0x04 with bit 0 clear sets `osd_en` from bit 1 and `pix16` from bit 2 (0 means 8 bits per pixel, 1 means 16), both from the next edge. A read of 0x04 returns enable in bit 1, width in bit 2 and the overflow flag in bit 8.
- R3: A write to 0x04 with bit 0 set empties the FIFO, clears `osd_en` and clears the overflow flag. Width is still taken from bit 2. Bit 0 always reads as 0.
- R4: Offset 0x08 holds X in bits 15:0 and Y in bits 31:16. Offset 0x0C holds width in bits 15:0 and height in bits 31:16. Both read back as written. The active window outputs change only on the `vid_clk` edge where `vid_vsync` is first seen high, and they then equal the shadow values.
- R5: A content write while the FIFO holds `DEPTH` words is discarded and sets the sticky overflow flag (bit 8 of 0x04).
- R6: `dma_req` rises one cycle after the level is at or below `DEPTH/2`. It falls one cycle after the level reaches `DEPTH`. Between those levels it keeps its previous value.
- R7: `irq_full` and `irq_empty` each pulse high for exactly one cycle, one cycle after the FIFO enters the full or empty state. Neither pulses out of reset.
- R8: A pop while the FIFO is empty changes neither `pop_data` nor the empty state. Writes to unmapped offsets are ignored, and reads of unmapped offsets return 0.
- R9: During reset `fifo_empty` is 1, and `osd_en`, `pix16`, `dma_req`, both interrupts and all window outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset, host domain |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, data on `bus_rdata` after the next edge |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pop | input | 1 | Consumer pop strobe |
| pop_data | output | 32 | Popped content word |
| fifo_empty | output | 1 | FIFO holds no word |
| osd_en | output | 1 | Overlay enable |
| pix16 | output | 1 | 1 = 16 bits per pixel, 0 = 8 |
| dma_req | output | 1 | Host DMA request |
| irq_full | output | 1 | Pulse on entering full |
| irq_empty | output | 1 | Pulse on entering empty |
| vid_clk | input | 1 | Video clock |
| vid_rst | input | 1 | Synchronous active-high reset, video domain |
| vid_vsync | input | 1 | Vertical sync, video domain |
| win_x | output | 16 | Active window X start |
| win_y | output | 16 | Active window Y start |
| win_w | output | 16 | Active window width |
| win_h | output | 16 | Active window height |

## Verification
The window properties assume that `vid_vsync` is already synchronous to `vid_clk`. They also assume the host leaves the shadow registers untouched for a few video cycles around a sync edge, because the shadow values cross domains without a handshake. The stimulus drives sync only on the falling edge of `vid_clk`, and performs shadow writes only while sync is low and stays low. The FIFO properties assume the host issues at most one of write or read per cycle. The bench never asserts both strobes together.

// File: rtl/osd_hif_pkg.sv
package osd_hif_pkg;
  localparam int OFS_DATA = 'h00;
  localparam int OFS_CTRL = 'h04;
  localparam int OFS_POS  = 'h08;
  localparam int OFS_SIZE = 'h0C;
  localparam int CB_RST   = 0;
  localparam int CB_EN    = 1;
  localparam int CB_W16   = 2;
  localparam int CB_OVF   = 8;
endpackage

// File: rtl/osd_hif_fifo.sv
module osd_hif_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/osd_hif_events.sv
module osd_hif_events #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  output logic          dma_req,
  output logic          irq_full,
  output logic          irq_empty
);
  logic is_full, is_empty, was_full, was_empty;

  assign is_full  = (count == CW'(DEPTH));
  assign is_empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req   <= 1'b0;
      irq_full  <= 1'b0;
      irq_empty <= 1'b0;
      was_full  <= 1'b0;
      was_empty <= 1'b1;
    end else begin
      if (is_full)                   dma_req <= 1'b0;
      else if (count <= CW'(HALF))   dma_req <= 1'b1;
      irq_full  <= is_full && !was_full;
      irq_empty <= is_empty && !was_empty;
      was_full  <= is_full;
      was_empty <= is_empty;
    end
  end
endmodule

// File: rtl/osd_hif_pos_sync.sv
module osd_hif_pos_sync #(
  parameter int PW = 16
) (
  input  logic          vid_clk,
  input  logic          vid_rst,
  input  logic          vid_vsync,
  input  logic [PW-1:0] sh_x,
  input  logic [PW-1:0] sh_y,
  input  logic [PW-1:0] sh_w,
  input  logic [PW-1:0] sh_h,
  output logic [PW-1:0] win_x,
  output logic [PW-1:0] win_y,
  output logic [PW-1:0] win_w,
  output logic [PW-1:0] win_h
);
  logic vs_q;

  always_ff @(posedge vid_clk) begin
    if (vid_rst) begin
      vs_q  <= 1'b0;
      win_x <= '0;
      win_y <= '0;
      win_w <= '0;
      win_h <= '0;
    end else begin
      vs_q <= vid_vsync;
      if (vid_vsync && !vs_q) begin
        win_x <= sh_x;
        win_y <= sh_y;
        win_w <= sh_w;
        win_h <= sh_h;
      end
    end
  end
endmodule

// File: rtl/osd_hif_top.sv
module osd_hif_top
  import osd_hif_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int DEPTH  = 256,
  parameter int PW     = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              pop,
  output logic [DW-1:0]     pop_data,
  output logic              fifo_empty,
  output logic              osd_en,
  output logic              pix16,
  output logic              dma_req,
  output logic              irq_full,
  output logic              irq_empty,
  input  logic              vid_clk,
  input  logic              vid_rst,
  input  logic              vid_vsync,
  output logic [PW-1:0]     win_x,
  output logic [PW-1:0]     win_y,
  output logic [PW-1:0]     win_w,
  output logic [PW-1:0]     win_h
);
  logic sel_data, sel_ctrl, sel_pos, sel_size;
  logic wr_data, wr_ctrl, soft_rst, ovf, fifo_full;
  logic [CW-1:0] level;
  logic [PW-1:0] sh_x, sh_y, sh_w, sh_h;

  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_pos  = (bus_addr == ADDR_W'(OFS_POS));
  assign sel_size = (bus_addr == ADDR_W'(OFS_SIZE));
  assign wr_data  = bus_wr && sel_data;
  assign wr_ctrl  = bus_wr && sel_ctrl;
  assign soft_rst = wr_ctrl && bus_wdata[CB_RST];

  osd_hif_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .flush(soft_rst), .push(wr_data),
    .wdata(bus_wdata), .pop(pop), .rdata(pop_data), .count(level),
    .full(fifo_full), .empty(fifo_empty)
  );

  osd_hif_events #(.DEPTH(DEPTH)) evt_i (
    .clk(clk), .rst(rst), .count(level),
    .dma_req(dma_req), .irq_full(irq_full), .irq_empty(irq_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      osd_en <= 1'b0;
      pix16  <= 1'b0;
      ovf    <= 1'b0;
      sh_x   <= '0;
      sh_y   <= '0;
      sh_w   <= '0;
      sh_h   <= '0;
    end else begin
      if (wr_ctrl) begin
        osd_en <= bus_wdata[CB_EN] && !bus_wdata[CB_RST];
        pix16  <= bus_wdata[CB_W16];
      end
      if (soft_rst)                  ovf <= 1'b0;
      else if (wr_data && fifo_full) ovf <= 1'b1;
      if (bus_wr && sel_pos) begin
        sh_x <= bus_wdata[PW-1:0];
        sh_y <= bus_wdata[2*PW-1:PW];
      end
      if (bus_wr && sel_size) begin
        sh_w <= bus_wdata[PW-1:0];
        sh_h <= bus_wdata[2*PW-1:PW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (sel_ctrl) begin
        bus_rdata[CB_EN]  <= osd_en;
        bus_rdata[CB_W16] <= pix16;
        bus_rdata[CB_OVF] <= ovf;
      end else if (sel_pos) begin
        bus_rdata <= {sh_y, sh_x};
      end else if (sel_size) begin
        bus_rdata <= {sh_h, sh_w};
      end
    end
  end

  osd_hif_pos_sync #(.PW(PW)) pos_i (
    .vid_clk(vid_clk), .vid_rst(vid_rst), .vid_vsync(vid_vsync),
    .sh_x(sh_x), .sh_y(sh_y), .sh_w(sh_w), .sh_h(sh_h),
    .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h)
  );
endmodule

// File: rtl/osd_hif_chk.sv
module osd_hif_chk
  import osd_hif_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int PW     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              pop,
  input logic              fifo_empty,
  input logic              osd_en,
  input logic              pix16,
  input logic              dma_req,
  input logic              irq_full,
  input logic              irq_empty,
  input logic              vid_clk,
  input logic              vid_rst,
  input logic              vid_vsync,
  input logic [PW-1:0]     win_x,
  input logic [PW-1:0]     win_h
);
  // R2
  ctrl_apply_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && !bus_wdata[CB_RST]
    |=> osd_en == $past(bus_wdata[CB_EN]) && pix16 == $past(bus_wdata[CB_W16]));

  // R3
  soft_flush_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CB_RST]
    |=> !osd_en && fifo_empty);

  // R6
  dma_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |=> dma_req);

  // R6
  dma_off_full_chk: assert property (@(posedge clk) disable iff (rst)
    irq_full |-> !dma_req);

  // R7
  irq_full_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_full |=> !irq_full);

  // R7
  irq_empty_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_empty |=> !irq_empty);

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    pop && fifo_empty && !bus_wr |=> fifo_empty);

  // R4
  win_x_frame_chk: assert property (@(posedge vid_clk) disable iff (vid_rst)
    !$stable(win_x) |-> $past(vid_vsync) && !$past(vid_vsync, 2));

  // R4
  win_h_frame_chk: assert property (@(posedge vid_clk) disable iff (vid_rst)
    !$stable(win_h) |-> $past(vid_vsync) && !$past(vid_vsync, 2));
endmodule

bind osd_hif_top osd_hif_chk #(.ADDR_W(ADDR_W), .DW(DW), .PW(PW)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pop(pop), .fifo_empty(fifo_empty),
  .osd_en(osd_en), .pix16(pix16), .dma_req(dma_req),
  .irq_full(irq_full), .irq_empty(irq_empty), .vid_clk(vid_clk),
  .vid_rst(vid_rst), .vid_vsync(vid_vsync), .win_x(win_x), .win_h(win_h)
);

// File: tb/osd_hif_top_tb_top.sv
module osd_hif_top_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int VCLK_PERIOD = 14;
  localparam int DEPTH       = 256;
  localparam int NVEC        = 6;
  // {addr, write data, expected readback}
  localparam logic [71:0] VECS [NVEC] = '{
    {8'h04, 32'h0000_0006, 32'h0000_0006},
    {8'h04, 32'h0000_0002, 32'h0000_0002},
    {8'h04, 32'h0000_0007, 32'h0000_0004},
    {8'h08, 32'h0020_0010, 32'h0020_0010},
    {8'h0C, 32'h00F0_0140, 32'h00F0_0140},
    {8'h10, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  logic clk = 0, vid_clk = 0;
  logic rst = 1, vid_rst = 1, vid_vsync = 0;
  logic bus_wr = 0, bus_rd = 0, pop = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pop_data;
  logic fifo_empty, osd_en, pix16, dma_req, irq_full, irq_empty;
  logic [15:0] win_x, win_y, win_w, win_h;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] rd, prev;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(VCLK_PERIOD/2) vid_clk = ~vid_clk;

  osd_hif_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pop(pop), .pop_data(pop_data), .fifo_empty(fifo_empty),
    .osd_en(osd_en), .pix16(pix16), .dma_req(dma_req),
    .irq_full(irq_full), .irq_empty(irq_empty), .vid_clk(vid_clk),
    .vid_rst(vid_rst), .vid_vsync(vid_vsync), .win_x(win_x),
    .win_y(win_y), .win_w(win_w), .win_h(win_h)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic do_pop();
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic vsync_pulse();
    @(negedge vid_clk); vid_vsync = 1;
    @(negedge vid_clk); @(negedge vid_clk); vid_vsync = 0;
    @(negedge vid_clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 fifo_empty", {31'b0, fifo_empty}, 32'd1);
    check("R9 flags", {26'b0, osd_en, pix16, dma_req, irq_full, irq_empty, 1'b0}, 32'd0);
    check("R9 window", {win_x, win_h}, 32'd0);
    @(negedge vid_clk); vid_rst = 0;
    @(negedge clk); rst = 0;
    @(negedge clk); @(negedge clk);
    check("R7 no irq after reset", {30'b0, irq_full, irq_empty}, 32'd0);

    // register vectors: R2 R3 R4 R8
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i][68:64], VECS[i][63:32]);
      rdreg(VECS[i][68:64], rd);
      check("R2/R3/R4/R8 readback", rd, VECS[i][31:0]);
      if (VECS[i][71:64] == 8'h04)
        check("R2 static outputs", {30'b0, pix16, osd_en}, {30'b0, VECS[i][2], VECS[i][1]});
    end

    // R4 window only moves at sync
    check("R4 held before sync", {win_x, win_y}, 32'd0);
    vsync_pulse();
    check("R4 x/y after sync", {win_y, win_x}, 32'h0020_0010);
    check("R4 w/h after sync", {win_h, win_w}, 32'h00F0_0140);
    wr(5'h08, 32'h0033_0044);
    repeat (6) @(negedge clk);
    check("R4 no sync no change", {win_y, win_x}, 32'h0020_0010);
    vsync_pulse();
    check("R4 second sync", {win_y, win_x}, 32'h0033_0044);

    // R1 order and unchanged data
    wr(5'h00, 32'hA5A5_0001);
    wr(5'h00, 32'h1234_5678);
    wr(5'h00, 32'hFFFF_0000);
    do_pop(); check("R1 word0", pop_data, 32'hA5A5_0001);
    do_pop(); check("R1 word1", pop_data, 32'h1234_5678);
    do_pop(); check("R1 word2", pop_data, 32'hFFFF_0000);
    check("R1 empty after drain", {31'b0, fifo_empty}, 32'd1);
    @(negedge clk);

    // fill to full: R5 R6 R7
    for (int i = 0; i < DEPTH - 1; i++) wr(5'h00, 32'h1000 + i);
    check("R6 held above half", {31'b0, dma_req}, 32'd1);
    wr(5'h00, 32'h1000 + DEPTH - 1);
    @(negedge clk);
    check("R7 irq_full pulse", {31'b0, irq_full}, 32'd1);
    check("R6 drop at full", {31'b0, dma_req}, 32'd0);
    @(negedge clk);
    check("R7 irq_full one cycle", {31'b0, irq_full}, 32'd0);
    wr(5'h00, 32'h0000_0BAD);
    rdreg(5'h04, rd);
    check("R5 overflow flag", {31'b0, rd[8]}, 32'd1);
    do_pop();
    check("R1 first of fill", pop_data, 32'h1000);
    for (int i = 1; i < DEPTH/2 - 1; i++) do_pop();
    @(negedge clk);
    check("R6 hysteresis off above half", {31'b0, dma_req}, 32'd0);
    do_pop();
    @(negedge clk);
    check("R6 on at half", {31'b0, dma_req}, 32'd1);
    for (int i = 0; i < DEPTH/2; i++) do_pop();
    check("R5 dropped word not stored", pop_data, 32'h1000 + DEPTH - 1);
    @(negedge clk);
    check("R7 irq_empty pulse", {31'b0, irq_empty}, 32'd1);
    @(negedge clk);
    check("R7 irq_empty one cycle", {31'b0, irq_empty}, 32'd0);
    prev = pop_data;
    do_pop(); @(negedge clk);
    check("R8 pop on empty data", pop_data, prev);
    check("R8 pop on empty state", {31'b0, fifo_empty}, 32'd1);

    // R3 soft reset flushes
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h2);
    wr(5'h04, 32'h0000_0002);
    check("R3 enable before", {31'b0, osd_en}, 32'd1);
    wr(5'h04, 32'h0000_0003);
    check("R3 flush empty", {31'b0, fifo_empty}, 32'd1);
    check("R3 enable cleared", {31'b0, osd_en}, 32'd0);
    @(negedge clk);
    check("R3 irq_empty on flush", {31'b0, irq_empty}, 32'd1);
    rdreg(5'h04, rd);
    check("R3 control after flush", rd, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule